// File: doc/BRIEF.md
# Multi-Channel Measurement Averaging Sequencer

This block drives the measurement loop of a hardware monitor. It visits six measurement channels one after another: channels 0 and 1 are remote diode sensors, channel 2 is the on-die diode, and channels 3, 4 and 5 are supply voltages. For every channel it sums a configured number of raw converter samples, divides the sum by that number with a right shift, and only then stores the result in that channel's reading register. The converter is outside the block and supplies a stream of samples, each marked by a valid strobe. The block shows which channel it wants next on a channel-select output.

An 8-bit control register sets the behaviour. Bits 7:5 form the averaging field. It is priority-decoded from its top bit down, and it gives remote diodes a different sample count from the other channels. Bit 2 enables the interrupt output. Bit 1 selects the monitoring mode: 0 is continuous, which wraps from channel 5 back to channel 0, and 1 is cycle mode, which runs one pass on a start pulse and then waits. Bits 4:3 and bit 0 are plain storage. The register resets to 0x40. A separate lock strobe freezes the register until the next reset.

Top module: `mon_avg_seq`

## Requirements
- R1: After reset the control register reads 0x40 and the lock flag is low. All six readings are 0, the channel select is 0, and the update strobe and interrupt are low.
- R2: Channels are served in the order 0,1,2,3,4,5. A reading changes only on the clock edge that accepts the last sample of its channel. On the following cycle, rd_upd is high for one cycle and rd_ch names that channel.
- R3: A reading equals floor(sum of its N samples / N). Cycles with smp_valid low are skipped and do not count. N=128 samples at full scale do not overflow.
- R4: When field bit 7 (averaging bit 2) is 1, every channel uses 32 samples, whatever bits 6:5 hold.
- R5: When the field is 01x, every channel uses 16 samples.
- R6: When the field is 001, channels 0 and 1 use 16 samples and channels 2 to 5 use 1 sample.
- R7: When the field is 000, channels 0 and 1 use 128 samples and channels 2 to 5 use 8 samples.
- R8: One cycle after cfg_lock is strobed, cfg_locked is high and stays high until reset. From then on, register writes have no effect.
- R9: In continuous mode (bit 1 = 0), the block moves from channel 5 straight to channel 0 and stays busy.
- R10: In cycle mode (bit 1 = 1), the block waits idle at channel 0 until a start pulse and then runs exactly one pass. While idle, samples are ignored. A start pulse during a pass is ignored.
- R11: The sample count of a channel is fixed from the field value at the moment that channel begins. A field write during a channel first affects the next channel.
- R12: When bit 2 is set, irq pulses for one cycle, in the same cycle as the rd_upd of the pass's final channel. When bit 2 is clear, irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_lock | input | 1 | Lock strobe, sticky until reset |
| cfg_rdata | output | 8 | Control register contents |
| cfg_locked | output | 1 | Lock flag |
| start | input | 1 | Pass start pulse (cycle mode) |
| smp_valid | input | 1 | Raw sample valid |
| smp_data | input | 10 | Raw sample value |
| ch_sel | output | 3 | Channel currently being measured |
| busy | output | 1 | A pass is in progress |
| rd_upd | output | 1 | One-cycle strobe after a reading is written |
| rd_ch | output | 3 | Channel of the last written reading |
| rd_data | output | 60 | Six readings, channel c in bits [10c+9:10c] |
| irq | output | 1 | End-of-pass interrupt pulse |

## Verification
The edge that accepts the last sample of a channel writes the reading and moves ch_sel on. rd_upd, rd_ch and irq are registered and are high for the cycle after that edge. A register write or start pulse shows on cfg_rdata or busy one edge after it is driven. The bench drives every input on the falling edge and checks on the next falling edge, half a cycle after the edge that should have acted. It also checks that each reading still holds its old value just before the last sample is driven. In every test the bench counts samples itself from the field decode. So a wrong count makes either the sample sum or the strobe timing disagree.

// File: rtl/mon_avg_pkg.sv
package mon_avg_pkg;

  localparam int AVG_MAX_SHIFT = 7;
  localparam int CFG_W         = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h40;

  localparam int BIT_MODE  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int FLD_LO    = 5;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  // Priority decode of the averaging field into log2(sample count).
  function automatic logic [2:0] avg_shift(input logic [2:0] fld, input logic remote);
    logic [2:0] s;
    if (fld[2])      s = 3'd5;
    else if (fld[1]) s = 3'd4;
    else if (fld[0]) s = remote ? 3'd4 : 3'd0;
    else             s = remote ? 3'd7 : 3'd3;
    return s;
  endfunction

endpackage

// File: rtl/mon_avg_rst_sync.sv
module mon_avg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mon_avg_cfg.sv
module mon_avg_cfg
  import mon_avg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lock_set,
  output logic [CFG_W-1:0] cfg,
  output logic             locked
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             lock_q, lock_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = we && !lock_q;
    cfg_d  = cfg_en ? wdata : cfg_q;
    lock_d = lock_q || lock_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      lock_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign cfg    = cfg_q;
  assign locked = lock_q;
endmodule

// File: rtl/mon_avg_fsm.sv
module mon_avg_fsm
  import mon_avg_pkg::*;
#(
  parameter int NUM_CH     = 6,
  parameter int NUM_REMOTE = 2,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_cycle,
  input  logic            start,
  input  logic            smp_valid,
  input  logic [2:0]      avg_field,
  output logic [CH_W-1:0] ch_sel,
  output logic            busy,
  output logic            first,
  output logic [2:0]      shift,
  output logic            wr_en,
  output logic            pass_done
);
  localparam int CNT_W = AVG_MAX_SHIFT + 1;
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

  seq_state_t      st_q, st_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_lim;
  logic [2:0]      shift_q, shift_d;
  logic            last;

  function automatic logic is_remote(input logic [CH_W-1:0] ch);
    return ch < CH_W'(NUM_REMOTE);
  endfunction

  always_comb begin
    cnt_lim = (CNT_W'(1) << shift_q) - CNT_W'(1);
    last    = (cnt_q == cnt_lim);
  end

  always_comb begin
    st_d      = st_q;
    ch_d      = ch_q;
    cnt_d     = cnt_q;
    shift_d   = shift_q;
    wr_en     = 1'b0;
    pass_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ch_d  = '0;
        cnt_d = '0;
        if (!mode_cycle || start) begin
          st_d    = ST_RUN;
          shift_d = avg_shift(avg_field, is_remote('0));
        end
      end
      ST_RUN: begin
        if (smp_valid) begin
          if (last) begin
            wr_en = 1'b1;
            cnt_d = '0;
            if (ch_q == CH_LAST) begin
              pass_done = 1'b1;
              ch_d      = '0;
              if (mode_cycle) st_d = ST_IDLE;
              else            shift_d = avg_shift(avg_field, is_remote('0));
            end else begin
              ch_d    = ch_q + CH_W'(1);
              shift_d = avg_shift(avg_field, is_remote(ch_q + CH_W'(1)));
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ch_q    <= '0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      st_q    <= st_d;
      ch_q    <= ch_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
    end
  end

  assign ch_sel = ch_q;
  assign busy   = (st_q == ST_RUN);
  assign first  = (cnt_q == '0);
  assign shift  = shift_q;
endmodule

// File: rtl/mon_avg_accum.sv
module mon_avg_accum
  import mon_avg_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                first,
  input  logic [2:0]          shift,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] result
);
  localparam int ACC_W = SAMPLE_W + AVG_MAX_SHIFT;

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum    = (first ? '0 : acc_q) + ACC_W'(sample);
    result = SAMPLE_W'(sum >> shift);
    acc_d  = en ? sum : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/mon_avg_bank.sv
module mon_avg_bank #(
  parameter int SAMPLE_W = 10,
  parameter int NUM_CH   = 6,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CH_W-1:0]            wr_ch,
  input  logic [SAMPLE_W-1:0]        wr_data,
  output logic [NUM_CH*SAMPLE_W-1:0] rd_flat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_rd
    logic [SAMPLE_W-1:0] val_q, val_d;
    logic                sel;

    always_comb begin
      sel   = wr_en && (wr_ch == CH_W'(i));
      val_d = sel ? wr_data : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign rd_flat[i*SAMPLE_W +: SAMPLE_W] = val_q;
  end
endmodule

// File: rtl/mon_avg_seq.sv
module mon_avg_seq
  import mon_avg_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int NUM_CH     = 6,
  parameter int NUM_REMOTE = 2,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic                       cfg_lock,
  output logic [CFG_W-1:0]           cfg_rdata,
  output logic                       cfg_locked,
  input  logic                       start,
  input  logic                       smp_valid,
  input  logic [SAMPLE_W-1:0]        smp_data,
  output logic [CH_W-1:0]            ch_sel,
  output logic                       busy,
  output logic                       rd_upd,
  output logic [CH_W-1:0]            rd_ch,
  output logic [NUM_CH*SAMPLE_W-1:0] rd_data,
  output logic                       irq
);
  logic                rst_sync_n;
  logic [CFG_W-1:0]    cfg;
  logic                first, wr_en, pass_done, busy_i;
  logic [2:0]          shift;
  logic [CH_W-1:0]     ch_i;
  logic [SAMPLE_W-1:0] avg_val;
  logic                acc_en;

  logic                upd_q, upd_d, irq_q, irq_d;
  logic [CH_W-1:0]     upd_ch_q, upd_ch_d;

  mon_avg_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mon_avg_cfg u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .wdata(cfg_wdata),
    .lock_set(cfg_lock), .cfg(cfg), .locked(cfg_locked)
  );

  mon_avg_fsm #(.NUM_CH(NUM_CH), .NUM_REMOTE(NUM_REMOTE)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .mode_cycle(cfg[BIT_MODE]), .start(start), .smp_valid(smp_valid),
    .avg_field(cfg[FLD_LO +: 3]),
    .ch_sel(ch_i), .busy(busy_i), .first(first), .shift(shift),
    .wr_en(wr_en), .pass_done(pass_done)
  );

  always_comb acc_en = smp_valid && busy_i;

  mon_avg_accum #(.SAMPLE_W(SAMPLE_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en(acc_en), .first(first),
    .shift(shift), .sample(smp_data), .result(avg_val)
  );

  mon_avg_bank #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_ch(ch_i),
    .wr_data(avg_val), .rd_flat(rd_data)
  );

  always_comb begin
    upd_d    = wr_en;
    upd_ch_d = wr_en ? ch_i : upd_ch_q;
    irq_d    = pass_done && cfg[BIT_IRQEN];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_q    <= 1'b0;
      upd_ch_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      upd_q    <= upd_d;
      upd_ch_q <= upd_ch_d;
      irq_q    <= irq_d;
    end
  end

  assign cfg_rdata = cfg;
  assign ch_sel    = ch_i;
  assign busy      = busy_i;
  assign rd_upd    = upd_q;
  assign rd_ch     = upd_ch_q;
  assign irq       = irq_q;
endmodule

// File: rtl/mon_avg_seq_chk.sv
module mon_avg_seq_chk #(
  parameter int SAMPLE_W = 10,
  parameter int NUM_CH   = 6,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [7:0]                 cfg_rdata,
  input logic                       cfg_locked,
  input logic [CH_W-1:0]            ch_sel,
  input logic                       busy,
  input logic                       rd_upd,
  input logic [CH_W-1:0]            rd_ch,
  input logic [NUM_CH*SAMPLE_W-1:0] rd_data,
  input logic                       irq
);
  assert_ch_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_sel < CH_W'(NUM_CH));

  assert_upd_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_upd |-> (rd_ch == $past(ch_sel)));

  assert_readings_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_upd |-> $stable(rd_data));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_locked) |-> cfg_locked);

  assert_locked_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_locked) |-> $stable(cfg_rdata));

  assert_idle_channel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ch_sel == '0));

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cfg_rdata[2]) && rd_upd));

  assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind mon_avg_seq mon_avg_seq_chk #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .cfg_locked(cfg_locked),
  .ch_sel(ch_sel), .busy(busy), .rd_upd(rd_upd), .rd_ch(rd_ch),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/test_mon_avg_seq.sv
module test_mon_avg_seq;
  localparam int SW = 10;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_lock, start, smp_valid;
  logic [7:0]    cfg_wdata, cfg_rdata;
  logic          cfg_locked, busy, rd_upd, irq;
  logic [SW-1:0] smp_data;
  logic [2:0]    ch_sel, rd_ch;
  logic [NC*SW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int exp_rd [NC];

  always #2 clk = ~clk;

  mon_avg_seq i_mon_avg_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_lock(cfg_lock), .cfg_rdata(cfg_rdata), .cfg_locked(cfg_locked),
    .start(start), .smp_valid(smp_valid), .smp_data(smp_data),
    .ch_sel(ch_sel), .busy(busy), .rd_upd(rd_upd), .rd_ch(rd_ch),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rd_of(input int ch);
    return int'(rd_data[ch*SW +: SW]);
  endfunction

  // Sample count from the field, written from the requirements R4..R7.
  function automatic int exp_n(input int fld, input int ch);
    bit remote = (ch < 2);
    if (fld[2])      return 32;
    else if (fld[1]) return 16;
    else if (fld[0]) return remote ? 16 : 1;
    else             return remote ? 128 : 8;
  endfunction

  function automatic int sval(input int salt, input int ch, input int k);
    if (salt == 0) return 1023;
    return (salt * 97 + ch * 211 + k * 53 + (k * k) % 17) % 1024;
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_channel(input int ch, input int n, input int salt,
                             input bit stall, input string tag);
    int sum = 0;
    for (int k = 0; k < n; k++) begin
      int v = sval(salt, ch, k);
      @(negedge clk);
      if (stall && (k % 3 == 1)) begin
        smp_valid = 1'b0;
        @(negedge clk);
      end
      if (k == 0) chk({tag, " R2 ch_sel order"}, int'(ch_sel), ch);
      if (k == n - 1) chk({tag, " R2 reading held before last"}, rd_of(ch), exp_rd[ch]);
      smp_valid = 1'b1;
      smp_data  = SW'(v);
      sum += v;
    end
    @(negedge clk);
    smp_valid  = 1'b0;
    exp_rd[ch] = sum / n;
    chk({tag, " R2 rd_upd"}, int'(rd_upd), 1);
    chk({tag, " R2 rd_ch"}, int'(rd_ch), ch);
    chk({tag, " R3 average"}, rd_of(ch), exp_rd[ch]);
  endtask

  task automatic run_pass(input int fld, input int salt, input bit stall,
                          input int exp_irq, input int exp_busy, input string tag);
    for (int ch = 0; ch < NC; ch++) run_channel(ch, exp_n(fld, ch), salt, stall, tag);
    chk({tag, " R12 irq at pass end"}, int'(irq), exp_irq);
    chk({tag, " busy after pass"}, int'(busy), exp_busy);
    chk({tag, " ch_sel back to 0"}, int'(ch_sel), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cfg reset", int'(cfg_rdata), 8'h40);
    chk("R1 lock reset", int'(cfg_locked), 0);
    chk("R1 ch_sel reset", int'(ch_sel), 0);
    chk("R1 rd_upd reset", int'(rd_upd), 0);
    chk("R1 irq reset", int'(irq), 0);
    for (int c = 0; c < NC; c++) chk("R1 reading reset", rd_of(c), 0);
  endtask

  task automatic t_continuous();
    run_pass(3'b010, 1, 1'b0, 0, 1, "R9 R5 continuous");
    cfg_write(8'h42);
    run_pass(3'b010, 2, 1'b1, 0, 0, "R10 last continuous pass");
  endtask

  task automatic t_idle_then_32();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = SW'(k * 100 + 7);
    end
    @(negedge clk); smp_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle busy", int'(busy), 0);
    chk("R10 idle rd_upd", int'(rd_upd), 0);
    chk("R10 idle ch_sel", int'(ch_sel), 0);
    chk("R10 idle reading", rd_of(0), exp_rd[0]);
    cfg_write(8'hE6);
    pulse_start();
    chk("R10 busy after start", int'(busy), 1);
    run_pass(3'b111, 3, 1'b0, 1, 0, "R4 field 1xx");
    @(negedge clk);
    chk("R12 irq one cycle", int'(irq), 0);
  endtask

  task automatic t_sixteen_start_ignored();
    cfg_write(8'h62);
    pulse_start();
    for (int ch = 0; ch < 3; ch++) run_channel(ch, 16, 5, 1'b0, "R5 field 011");
    pulse_start();
    for (int ch = 3; ch < NC; ch++) run_channel(ch, 16, 5, 1'b0, "R5 field 011");
    chk("R10 start in pass ignored", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R10 still idle", int'(busy), 0);
  endtask

  task automatic t_one();
    cfg_write(8'h22);
    pulse_start();
    run_pass(3'b001, 4, 1'b0, 0, 0, "R6 field 001");
  endtask

  task automatic t_long();
    cfg_write(8'h02);
    pulse_start();
    run_pass(3'b000, 0, 1'b1, 0, 0, "R7 R3 field 000 full scale");
  endtask

  task automatic t_switch();
    cfg_write(8'h42);
    pulse_start();
    cfg_write(8'h02);
    run_channel(0, 16, 6, 1'b0, "R11 old count kept");
    run_channel(1, 128, 6, 1'b0, "R11 new remote count");
    for (int ch = 2; ch < NC; ch++) run_channel(ch, 8, 6, 1'b0, "R11 new local count");
    chk("R11 pass ends", int'(busy), 0);
  endtask

  task automatic t_lock();
    cfg_write(8'h46);
    @(negedge clk); cfg_lock = 1'b1;
    @(negedge clk); cfg_lock = 1'b0;
    chk("R8 locked flag", int'(cfg_locked), 1);
    cfg_write(8'h1D);
    chk("R8 write ignored", int'(cfg_rdata), 8'h46);
    pulse_start();
    run_pass(3'b010, 7, 1'b0, 1, 0, "R8 field kept");
    chk("R8 lock sticky", int'(cfg_locked), 1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cfg_lock = 1'b0;
    start = 1'b0; smp_valid = 1'b0; smp_data = '0;
    for (int c = 0; c < NC; c++) exp_rd[c] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_continuous();
    t_idle_then_32();
    t_sixteen_start_ignored();
    t_one();
    t_long();
    t_switch();
    t_lock();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule